// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator

This block takes a received Reed-Solomon codeword of fifteen 4-bit symbols over GF(2^4). The symbols arrive one per cycle. It produces the six syndromes that a (15,9) code needs to correct up to three symbol errors. The field uses the primitive polynomial x^4 + x + 1. Field addition is bitwise XOR. A multiply by alpha reduces alpha^4 to alpha + 1.

The block keeps one Horner accumulator per syndrome. For each accepted symbol, syndrome i is multiplied by the constant alpha^i and the new symbol is XORed in. The constant multipliers are built into the block.

A start strobe marks the first symbol of a word and clears the accumulators in the same cycle. After the fifteenth accepted symbol, a one-cycle done strobe comes out. The syndromes and an error flag then stay held until the next start. The error flag is high when any syndrome is nonzero, which means the word contains errors. Locating and correcting the errors is left to downstream logic.

Top module: `rs_syndrome_calc`

## Requirements
- R1: After reset, `done_o` and `err_o` are 0 and `synd_o` is all zeros.
- R2: When a word completes, the syndrome field `synd_o[4*(i-1)+:4]` equals r(alpha^i) for i = 1..6.
  - Here r(x) has the first symbol of the word as the coefficient of x^14 and the last as the coefficient of x^0.
  - Products are reduced with x^4 + x + 1. Alpha is the symbol 4'b0010.
- R3: A word that is a multiple of g(x) = (x+alpha)(x+alpha^2)...(x+alpha^6) gives all-zero syndromes and `err_o` = 0.
- R4: When a word completes, `err_o` is 1 exactly when at least one syndrome is nonzero.
- R5: `done_o` is high for exactly one cycle, in the cycle after the clock edge that accepts the fifteenth symbol.
- R6: Cycles with `valid_i` low are ignored. A word sent with idle gaps gives the same syndromes and flag as the same word sent back to back.
- R7: A symbol with `valid_i` and `start_i` both high always begins a new word, even in the middle of a word. Symbols received before it do not affect the result.
- R8: After completion, `synd_o` and `err_o` hold their values until the next start. Valid symbols without a start are then ignored, and `done_o` stays low.
- R9: From the cycle after a start until the word completes, `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Marks the first symbol of a word; only acted on together with `valid_i` |
| valid_i | input | 1 | `sym_i` carries a symbol this cycle |
| sym_i | input | 4 | Received symbol, highest-degree coefficient first |
| done_o | output | 1 | One-cycle strobe: a word is complete |
| synd_o | output | 24 | Six 4-bit syndromes, S1 in bits [3:0] up to S6 in bits [23:20] |
| err_o | output | 1 | A completed word has at least one nonzero syndrome |

## Verification
The bench builds the block with its default parameters: 4-bit symbols, the tap pattern of x^4 + x + 1, fifteen symbols and six syndromes. These values make real (15,9) codewords possible. The bench builds such a codeword by multiplying a message polynomial by the generator g(x). It can then check an all-zero result and a controlled single-symbol error against reference syndromes. The bench computes those reference syndromes by direct power sums, not by Horner's rule. Gap patterns, a restart in the middle of a word, and stray symbols after completion check the pause, restart and hold behaviour.

// File: rtl/rs_syndrome_calc.sv
module rs_syndrome_calc #(
  parameter int          SYM_W    = 4,
  parameter logic [3:0]  POLY_TAP = 4'b0011,
  parameter int          N_SYM    = 15,
  parameter int          N_SYND   = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    valid_i,
  input  logic [SYM_W-1:0]        sym_i,
  output logic                    done_o,
  output logic [N_SYND*SYM_W-1:0] synd_o,
  output logic                    err_o
);
  localparam int CNT_W = $clog2(N_SYM + 1);

  function automatic logic [SYM_W-1:0] mul_apow(input logic [SYM_W-1:0] x, input int p);
    logic [SYM_W-1:0] v;
    v = x;
    for (int k = 0; k < p; k++)
      v = {v[SYM_W-2:0], 1'b0} ^ (v[SYM_W-1] ? POLY_TAP[SYM_W-1:0] : '0);
    return v;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             have_q;
  logic             take;
  logic [CNT_W-1:0] cnt_nx;

  assign take   = valid_i && (start_i || cnt_q != '0);
  assign cnt_nx = start_i ? CNT_W'(1) : cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
      have_q <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (take) begin
        if (start_i) have_q <= 1'b0;
        if (cnt_nx == CNT_W'(N_SYM)) begin
          cnt_q  <= '0;
          done_o <= 1'b1;
          have_q <= 1'b1;
        end else begin
          cnt_q <= cnt_nx;
        end
      end
    end
  end

  for (genvar i = 0; i < N_SYND; i++) begin : g_synd
    logic [SYM_W-1:0] acc_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (take)  acc_q <= (start_i ? '0 : mul_apow(acc_q, i + 1)) ^ sym_i;
    end
    assign synd_o[i*SYM_W +: SYM_W] = acc_q;
  end

  assign err_o = have_q && (synd_o != '0);
endmodule

// File: rtl/rs_syndrome_calc_chk.sv
module rs_syndrome_calc_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         valid_i,
  input logic         done_o,
  input logic         err_o,
  input logic         have_q,
  input logic [W-1:0] synd_o
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5
  AST_DONE_AFTER_SYM: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(valid_i)); // R5
  AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (err_o == (synd_o != '0))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(synd_o)); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (have_q && !(valid_i && start_i)) |=> ($stable(synd_o) && $stable(err_o) && !done_o)); // R8
  AST_START_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && start_i) |=> !err_o); // R9
endmodule

bind rs_syndrome_calc rs_syndrome_calc_chk #(.W(N_SYND*SYM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
  .done_o(done_o), .err_o(err_o), .have_q(have_q), .synd_o(synd_o)
);

// File: tb/sim_rs_syndrome_calc.sv
module sim_rs_syndrome_calc;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, valid_i = 1'b0;
  logic [3:0]  sym_i = '0;
  logic        done_o, err_o;
  logic [23:0] synd_o;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  rs_syndrome_calc u0 (.clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
                       .sym_i(sym_i), .done_o(done_o), .synd_o(synd_o), .err_o(err_o));

  typedef struct packed { logic [59:0] w; logic [14:0] gap; } vec_t;
  localparam vec_t VEC [5] = '{
    '{60'h000000000000000, 15'h0000},
    '{60'h0123456789ABCDE, 15'h0000},
    '{60'hFEDCBA987654321, 15'h5555},
    '{60'h800000000000000, 15'h0001},
    '{60'h000000000000001, 15'h4210}
  };

  function automatic logic [3:0] gf_mul(input logic [3:0] a, input logic [3:0] b);
    logic [6:0] p = '0;
    for (int k = 0; k < 4; k++) if (b[k]) p ^= 7'(a) << k;
    for (int k = 6; k >= 4; k--) if (p[k]) p ^= 7'b0010011 << (k - 4);
    return p[3:0];
  endfunction

  function automatic logic [3:0] apow(input int n);
    logic [3:0] v = 4'd1;
    for (int k = 0; k < n % 15; k++) v = gf_mul(v, 4'd2);
    return v;
  endfunction

  function automatic logic [23:0] ref_synd(input logic [59:0] w);
    logic [23:0] s = '0;
    for (int i = 1; i <= 6; i++)
      for (int j = 0; j < 15; j++)
        s[(i-1)*4 +: 4] ^= gf_mul(w[j*4 +: 4], apow(i*j));
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [59:0] w, input logic [14:0] gap);
    for (int k = 0; k < 15; k++) begin
      if (gap[k]) begin @(negedge clk); valid_i = 1'b0; start_i = 1'b0; end
      @(negedge clk); valid_i = 1'b1; start_i = (k == 0); sym_i = w[59-4*k -: 4];
    end
    @(negedge clk); valid_i = 1'b0; start_i = 1'b0;
  endtask

  task automatic check_word(input string tag, input logic [59:0] w);
    logic [23:0] e = ref_synd(w);
    chk({tag, " R5 done"}, 32'(done_o), 32'd1);
    chk({tag, " R2 synd"}, 32'(synd_o), 32'(e));
    chk({tag, " R4 err"}, 32'(err_o), 32'(e != '0));
    @(negedge clk);
    chk({tag, " R5 done low"}, 32'(done_o), 32'd0);
  endtask

  logic [3:0]  g [7];
  logic [3:0]  c [15];
  logic [59:0] cw;

  initial begin
    #(CLK_P*100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done", 32'(done_o), 32'd0);
    chk("R1 err", 32'(err_o), 32'd0);
    chk("R1 synd", 32'(synd_o), 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < 5; v++) begin
      send(VEC[v].w, VEC[v].gap);
      check_word($sformatf("vec%0d R6", v), VEC[v].w);
    end

    for (int k = 0; k < 7; k++) g[k] = (k == 0) ? 4'd1 : 4'd0;
    for (int i = 1; i <= 6; i++)
      for (int k = 6; k >= 0; k--)
        g[k] = (k > 0 ? g[k-1] : 4'd0) ^ gf_mul(g[k], apow(i));
    for (int j = 0; j < 15; j++) c[j] = '0;
    for (int m = 0; m < 9; m++)
      for (int k = 0; k < 7; k++) c[m+k] ^= gf_mul(4'(m + 3), g[k]);
    for (int j = 0; j < 15; j++) cw[j*4 +: 4] = c[j];

    for (int k = 0; k < 15; k++) begin
      @(negedge clk); valid_i = 1'b1; start_i = (k == 0); sym_i = cw[59-4*k -: 4];
      if (k == 1) chk("R9 err in word", 32'(err_o), 32'd0);
    end
    @(negedge clk); valid_i = 1'b0; start_i = 1'b0;
    chk("R3 codeword synd", 32'(synd_o), 32'd0);
    chk("R3 codeword err", 32'(err_o), 32'd0);
    chk("R3 done", 32'(done_o), 32'd1);

    send(cw ^ (60'h5 << 28), 15'h0000);
    check_word("R4 single error", cw ^ (60'h5 << 28));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); valid_i = 1'b1; start_i = 1'b0; sym_i = 4'(k + 9);
      @(negedge clk); valid_i = 1'b0;
      chk("R8 held synd", 32'(synd_o), 32'(ref_synd(cw ^ (60'h5 << 28))));
      chk("R8 held err", 32'(err_o), 32'd1);
      chk("R8 no done", 32'(done_o), 32'd0);
    end

    for (int k = 0; k < 5; k++) begin
      @(negedge clk); valid_i = 1'b1; start_i = (k == 0); sym_i = 4'hF;
    end
    send(VEC[1].w, 15'h0000);
    check_word("R7 restart", VEC[1].w);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule